// File: doc/BRIEF.md
# Control Register Write Side-Effect Unit

This block is the write path for a processor's control registers, its extended-feature register, the timestamp counter and the segment base and attribute registers. A single write port carries an index, data and an enable. A write to one register can change the state of other registers: the long-mode-active bit follows paging, and effective segment bases are zeroed or reloaded when the code-segment long-mode attribute changes. Writes also raise one-cycle pulses that tell the translation buffers to flush everything, or only their non-global entries. A further strobe tells the mode decoder to recompute its state.

The timestamp counter is not stored as a running count. The block keeps an offset from a free-running cycle counter and adds the two back together on a read. A combinational read port returns any register. Indices that are reserved or read-only are refused, and each such access raises an illegal-access pulse.

Index map (6-bit index): 0, 2, 3, 4 and 8 are the control registers of those numbers, 16 is the extended-feature register, 17 is the timestamp, and 18 to 26 are the actual segment bases. The base order at 18 to 26 is ES, CS, SS, DS, FS, GS, the global table, the interrupt table and the task register. 27 holds the code-segment attributes and 28 the stack-segment attributes. 32 to 40 are the read-only effective bases, in the same segment order.

Top module: `ctlreg_wr_unit`

## Requirements
- R1: After reset every readable register reads 0 and every pulse output is low.
- R2: A write to index 0 always stores bit 4 as 1, whatever the written bit 4 is.
- R3: When a write to index 0 flips bit 31 and bit 8 of index 16 is 1, bit 10 of index 16 takes the new bit 31. When bit 8 of index 16 is 0, bit 10 is left unchanged.
- R4: A write to index 0 that flips bit 31 sets `flush_all` high for exactly the next cycle. A write to index 0 that leaves bit 31 unchanged does not.
- R5: Every write to index 3 sets `flush_nonglobal` high for exactly the next cycle. No other write does so.
- R6: A write to index 4 that flips bit 4, 5 or 7 sets `flush_all` for the next cycle. A write to index 4 that flips only other bits does not.
- R7: When a write to index 27 flips bit 1 to 1, the effective bases of ES, CS, SS and DS (indices 32 to 35) become 0. When it flips bit 1 to 0, those effective bases are reloaded from the actual bases.
- R8: A write to a base at indices 22 to 26 always copies the value into the matching effective base. A write to a base at indices 18 to 21 copies it only when bit 10 of index 16 and bit 1 of index 27 are not both 1. The actual base always takes the value.
- R9: A write of V to index 17 makes index 17 read V+1 one cycle later. Index 17 then advances by one every cycle.
- R10: A write to any index other than 0, 2, 3, 4, 8 and 16 to 28 changes no register and raises `illegal_access` for the next cycle. A read with `rd_en` of an index other than those and 32 to 40 returns 0 and raises `illegal_access` for the next cycle.
- R11: `mode_recalc` is high for exactly the cycle after any write to index 0, 27 or 28, and low otherwise.
- R12: Every other legal write stores the written value unchanged, and the value is visible on `rd_data` in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 6 | Write register index |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Read qualifier, used only to flag illegal reads |
| rd_idx | input | 6 | Read register index |
| rd_data | output | 64 | Combinational read data |
| flush_all | output | 1 | Full translation-buffer flush pulse |
| flush_nonglobal | output | 1 | Non-global-entry flush pulse |
| mode_recalc | output | 1 | Mode-decoder recompute strobe |
| illegal_access | output | 1 | Illegal index access pulse |

## Verification
Every result of a write is due one clock edge after the edge that accepts it. This covers the stored registers, the effective bases and the four pulse outputs. A read is combinational on the current state. The timestamp read moves on by one at every edge. The bench drives each operation at a falling edge and updates its reference model before the rising edge, using the model's own cycle count. It then compares all four pulses and the read of a chosen index at the next falling edge. This means every clock is checked exactly in the cycle its result is due, and any pulse that lasts too long shows up on the following compare.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int IDX_W = 6;
  localparam int NSEG  = 9;
  localparam int NLEG  = 4;

  localparam logic [IDX_W-1:0] IX_CR0    = 6'd0;
  localparam logic [IDX_W-1:0] IX_CR2    = 6'd2;
  localparam logic [IDX_W-1:0] IX_CR3    = 6'd3;
  localparam logic [IDX_W-1:0] IX_CR4    = 6'd4;
  localparam logic [IDX_W-1:0] IX_CR8    = 6'd8;
  localparam logic [IDX_W-1:0] IX_XFEAT  = 6'd16;
  localparam logic [IDX_W-1:0] IX_TSTAMP = 6'd17;
  localparam logic [IDX_W-1:0] IX_BASE0  = 6'd18;
  localparam logic [IDX_W-1:0] IX_CSATTR = 6'd27;
  localparam logic [IDX_W-1:0] IX_SSATTR = 6'd28;
  localparam logic [IDX_W-1:0] IX_EFF0   = 6'd32;

  localparam int B_PE = 0, B_ET = 4, B_PG = 31;
  localparam int B_PSE = 4, B_PAE = 5, B_PGE = 7;
  localparam int B_LME = 8, B_LMA = 10;
  localparam int B_CSL = 1;

  function automatic logic wr_legal(logic [IDX_W-1:0] ix);
    return ix == IX_CR0 || ix == IX_CR2 || ix == IX_CR3 || ix == IX_CR4 ||
           ix == IX_CR8 || (ix >= IX_XFEAT && ix <= IX_SSATTR);
  endfunction

  function automatic logic rd_legal(logic [IDX_W-1:0] ix);
    return wr_legal(ix) || (ix >= IX_EFF0 && ix < IX_EFF0 + IDX_W'(NSEG));
  endfunction

  function automatic logic [63:0] stamp_store(logic [63:0] v, logic [63:0] cyc);
    return v - cyc;
  endfunction

  function automatic logic [63:0] stamp_view(logic [63:0] off, logic [63:0] cyc);
    return off + cyc;
  endfunction
endpackage

// File: rtl/ctlreg_tstamp.sv
module ctlreg_tstamp #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] view
);
  import ctlreg_pkg::*;
  logic [DW-1:0] cyc_q, off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
      off_q <= '0;
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (wr) off_q <= DW'(stamp_store(64'(wdata), 64'(cyc_q)));
    end
  end

  assign view = DW'(stamp_view(64'(off_q), 64'(cyc_q)));

  // R9
  stamp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> view == $past(wdata) + 1'b1);
endmodule

// File: rtl/ctlreg_segfile.sv
module ctlreg_segfile #(
  parameter int DW   = 64,
  parameter int NSEG = 9,
  parameter int NLEG = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSEG-1:0] wr_seg,
  input  logic [DW-1:0]   wdata,
  input  logic            lm64,
  input  logic            lm_rise,
  input  logic            lm_fall,
  output logic [DW-1:0]   base_q [NSEG],
  output logic [DW-1:0]   eff_q  [NSEG]
);
  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) base_q[i] <= '0;
      else if (wr_seg[i]) base_q[i] <= wdata;
    end

    if (i < NLEG) begin : g_legacy
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   eff_q[i] <= '0;
        else if (lm_rise)             eff_q[i] <= '0;
        else if (lm_fall)             eff_q[i] <= base_q[i];
        else if (wr_seg[i] && !lm64)  eff_q[i] <= wdata;
      end
      // R7
      eff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lm_rise |=> eff_q[i] == '0);
      // R8
      eff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_seg[i] && lm64) |=> $stable(eff_q[i]));
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         eff_q[i] <= '0;
        else if (wr_seg[i]) eff_q[i] <= wdata;
      end
      // R8
      eff_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_seg[i] |=> eff_q[i] == $past(wdata));
    end
  end
endmodule

// File: rtl/ctlreg_wr_unit.sv
module ctlreg_wr_unit #(
  parameter int DW = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ctlreg_pkg::IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]               wr_data,
  input  logic                        rd_en,
  input  logic [ctlreg_pkg::IDX_W-1:0] rd_idx,
  output logic [DW-1:0]               rd_data,
  output logic                        flush_all,
  output logic                        flush_nonglobal,
  output logic                        mode_recalc,
  output logic                        illegal_access
);
  import ctlreg_pkg::*;
  localparam logic [DW-1:0] CR4_WATCH = DW'((1 << B_PSE) | (1 << B_PAE) | (1 << B_PGE));

  logic [DW-1:0] cr0_q, cr2_q, cr3_q, cr4_q, cr8_q, xfeat_q, csattr_q, ssattr_q;
  logic [DW-1:0] stamp_view_w;
  logic [DW-1:0] base_q [NSEG];
  logic [DW-1:0] eff_q  [NSEG];
  logic [NSEG-1:0] wr_seg;

  // named internal events
  logic wr_ok, hit_cr0, hit_cr3, hit_cr4, hit_cs, hit_ss, hit_stamp;
  logic pg_flip, cr4_flip, csl_flip, lm_rise, lm_fall, lm64, rd_bad;

  assign wr_ok     = wr_en && wr_legal(wr_idx);
  assign hit_cr0   = wr_ok && wr_idx == IX_CR0;
  assign hit_cr3   = wr_ok && wr_idx == IX_CR3;
  assign hit_cr4   = wr_ok && wr_idx == IX_CR4;
  assign hit_cs    = wr_ok && wr_idx == IX_CSATTR;
  assign hit_ss    = wr_ok && wr_idx == IX_SSATTR;
  assign hit_stamp = wr_ok && wr_idx == IX_TSTAMP;
  assign pg_flip   = hit_cr0 && (wr_data[B_PG] != cr0_q[B_PG]);
  assign cr4_flip  = hit_cr4 && |((wr_data ^ cr4_q) & CR4_WATCH);
  assign csl_flip  = hit_cs && (wr_data[B_CSL] != csattr_q[B_CSL]);
  assign lm_rise   = csl_flip && wr_data[B_CSL];
  assign lm_fall   = csl_flip && !wr_data[B_CSL];
  assign lm64      = xfeat_q[B_LMA] && csattr_q[B_CSL];
  assign rd_bad    = rd_en && !rd_legal(rd_idx);

  for (genvar s = 0; s < NSEG; s++) begin : g_dec
    assign wr_seg[s] = wr_ok && wr_idx == IX_BASE0 + IDX_W'(s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr0_q <= '0; cr2_q <= '0; cr3_q <= '0; cr4_q <= '0; cr8_q <= '0;
      xfeat_q <= '0; csattr_q <= '0; ssattr_q <= '0;
      flush_all <= 1'b0; flush_nonglobal <= 1'b0;
      mode_recalc <= 1'b0; illegal_access <= 1'b0;
    end else begin
      flush_all       <= pg_flip || cr4_flip;
      flush_nonglobal <= hit_cr3;
      mode_recalc     <= hit_cr0 || hit_cs || hit_ss;
      illegal_access  <= (wr_en && !wr_legal(wr_idx)) || rd_bad;
      if (hit_cr0) begin
        cr0_q <= wr_data | (DW'(1) << B_ET);
        if (pg_flip && xfeat_q[B_LME]) xfeat_q[B_LMA] <= wr_data[B_PG];
      end
      if (wr_ok) begin
        case (wr_idx)
          IX_CR2:    cr2_q    <= wr_data;
          IX_CR3:    cr3_q    <= wr_data;
          IX_CR4:    cr4_q    <= wr_data;
          IX_CR8:    cr8_q    <= wr_data;
          IX_XFEAT:  xfeat_q  <= wr_data;
          IX_CSATTR: csattr_q <= wr_data;
          IX_SSATTR: ssattr_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  ctlreg_tstamp #(.DW(DW)) u_stamp (
    .clk(clk), .rst_n(rst_n), .wr(hit_stamp), .wdata(wr_data), .view(stamp_view_w)
  );

  ctlreg_segfile #(.DW(DW), .NSEG(NSEG), .NLEG(NLEG)) u_seg (
    .clk(clk), .rst_n(rst_n), .wr_seg(wr_seg), .wdata(wr_data), .lm64(lm64),
    .lm_rise(lm_rise), .lm_fall(lm_fall), .base_q(base_q), .eff_q(eff_q)
  );

  always_comb begin
    rd_data = '0;
    case (rd_idx)
      IX_CR0:    rd_data = cr0_q;
      IX_CR2:    rd_data = cr2_q;
      IX_CR3:    rd_data = cr3_q;
      IX_CR4:    rd_data = cr4_q;
      IX_CR8:    rd_data = cr8_q;
      IX_XFEAT:  rd_data = xfeat_q;
      IX_TSTAMP: rd_data = stamp_view_w;
      IX_CSATTR: rd_data = csattr_q;
      IX_SSATTR: rd_data = ssattr_q;
      default: ;
    endcase
    for (int s = 0; s < NSEG; s++) begin
      if (rd_idx == IX_BASE0 + IDX_W'(s)) rd_data = base_q[s];
      if (rd_idx == IX_EFF0 + IDX_W'(s))  rd_data = eff_q[s];
    end
  end

  // R2
  et_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cr0 |=> cr0_q[B_ET]);
  // R3
  lma_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_flip && xfeat_q[B_LME]) |=> xfeat_q[B_LMA] == $past(wr_data[B_PG]));
  // R4
  pg_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_flip |=> flush_all);
  // R5
  ng_flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_nonglobal |-> $past(wr_en && wr_idx == IX_CR3));
  // R10
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_legal(wr_idx)) |=> illegal_access);
  // R11
  recalc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_recalc |-> $past(wr_en && (wr_idx == IX_CR0 || wr_idx == IX_CSATTR ||
                                    wr_idx == IX_SSATTR)));
endmodule

// File: tb/sim_ctlreg_wr_unit.sv
`timescale 1ns/1ps
module sim_ctlreg_wr_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] wr_idx = '0, rd_idx = '0;
  logic [63:0] wr_data = '0, rd_data;
  logic flush_all, flush_nonglobal, mode_recalc, illegal_access;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [63:0] mr [0:63];
  logic [63:0] off_m = '0, cyc_m = '0;
  logic e_fa = 0, e_fng = 0, e_rc = 0, e_ill = 0;

  always #2 clk = ~clk;

  ctlreg_wr_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data), .flush_all(flush_all),
    .flush_nonglobal(flush_nonglobal), .mode_recalc(mode_recalc),
    .illegal_access(illegal_access)
  );

  function automatic bit m_wr_ok(int ix);
    return ix == 0 || ix == 2 || ix == 3 || ix == 4 || ix == 8 || (ix >= 16 && ix <= 28);
  endfunction
  function automatic bit m_rd_ok(int ix);
    return m_wr_ok(ix) || (ix >= 32 && ix <= 40);
  endfunction
  function automatic logic [63:0] m_read(int ix);
    if (!m_rd_ok(ix)) return 64'd0;
    if (ix == 17) return off_m + cyc_m;
    return mr[ix];
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_write(int ix, logic [63:0] v);
    if (!m_wr_ok(ix)) begin e_ill = 1; return; end
    case (ix)
      0: begin
        if (mr[0][31] != v[31]) begin
          e_fa = 1;
          if (mr[16][8]) mr[16][10] = v[31];
        end
        mr[0] = v | 64'h10;
        e_rc = 1;
      end
      3: begin mr[3] = v; e_fng = 1; end
      4: begin
        if (((mr[4] ^ v) & 64'hB0) != 0) e_fa = 1;
        mr[4] = v;
      end
      17: off_m = v - cyc_m;
      27: begin
        if (mr[27][1] != v[1])
          for (int s = 0; s < 4; s++) mr[32+s] = v[1] ? 64'd0 : mr[18+s];
        mr[27] = v;
        e_rc = 1;
      end
      28: begin mr[28] = v; e_rc = 1; end
      default: begin
        if (ix >= 18 && ix <= 26) begin
          if (ix >= 22 || !(mr[16][10] && mr[27][1])) mr[32+ix-18] = v;
        end
        mr[ix] = v;
      end
    endcase
  endtask

  // one clock: drive at falling edge, compare at the next falling edge
  task automatic cyc_op(bit we, int wi, logic [63:0] wv, bit re, int ri, string tag);
    wr_en = we; wr_idx = 6'(wi); wr_data = wv; rd_en = re; rd_idx = 6'(ri);
    e_fa = 0; e_fng = 0; e_rc = 0; e_ill = 0;
    if (we) model_write(wi, wv);
    if (re && !m_rd_ok(ri)) e_ill = 1;
    @(posedge clk);
    @(negedge clk);
    cyc_m++;
    wr_en = 0; rd_en = 0;
    check({tag, " flush_all (R4/R6)"}, 64'(flush_all), 64'(e_fa));
    check({tag, " flush_nonglobal (R5)"}, 64'(flush_nonglobal), 64'(e_fng));
    check({tag, " mode_recalc (R11)"}, 64'(mode_recalc), 64'(e_rc));
    check({tag, " illegal_access (R10)"}, 64'(illegal_access), 64'(e_ill));
    check({tag, " rd_data"}, rd_data, m_read(ri));
  endtask

  task automatic wr(int wi, logic [63:0] wv, int ri, string tag);
    cyc_op(1, wi, wv, 0, ri, tag);
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 41; i++) cyc_op(0, 0, 0, 1, i, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mr[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state, pulses low
    check("R1 flush_all", 64'(flush_all), 0);
    check("R1 mode_recalc", 64'(mode_recalc), 0);
    rst_n = 1;
    sweep("R1 reset read");
    wr(0, 64'h1, 0, "R2 ET forced");
    wr(0, 64'h0, 0, "R2 ET forced on zero");
    wr(16, 64'h100, 16, "R12 set LME");
    wr(0, 64'h8000_0001, 16, "R3 PG on sets LMA");
    cyc_op(0, 0, 0, 0, 0, "R4 pulse drops");
    wr(0, 64'h8000_0003, 0, "R4 no PG flip");
    wr(3, 64'hABCD_0000, 3, "R5 CR3 write");
    cyc_op(0, 0, 0, 0, 3, "R5 pulse drops");
    wr(4, 64'h1, 4, "R6 non-watched bit");
    wr(4, 64'h21, 4, "R6 PAE flip");
    wr(4, 64'hA1, 4, "R6 PGE flip");
    wr(4, 64'h1A1, 4, "R6 bit8 only");
    wr(4, 64'h191, 4, "R6 PSE flip");
    wr(2, 64'h55, 2, "R12 CR2");
    wr(8, 64'h7, 8, "R12 CR8");
    wr(18, 64'h1000, 32, "R8 ES base legacy");
    wr(21, 64'h1400, 35, "R8 DS base legacy");
    wr(22, 64'h2000, 36, "R8 FS base");
    wr(27, 64'h2, 32, "R7 L rise zeroes");
    cyc_op(0, 0, 0, 0, 35, "R7 DS eff zero");
    wr(18, 64'h3000, 32, "R8 ES base in 64-bit");
    cyc_op(0, 0, 0, 0, 18, "R8 ES actual base");
    wr(23, 64'h4000, 37, "R8 GS base in 64-bit");
    wr(26, 64'h5000, 40, "R8 TR base");
    wr(27, 64'h0, 32, "R7 L fall reloads");
    cyc_op(0, 0, 0, 0, 35, "R7 DS reload");
    wr(28, 64'h40, 28, "R11 SS attr");
    wr(17, 64'h1000, 17, "R9 stamp write");
    repeat (5) cyc_op(0, 0, 0, 0, 17, "R9 stamp runs");
    wr(5, 64'hFFFF, 5, "R10 CR5 write");
    wr(34, 64'hFFFF, 34, "R10 eff write");
    wr(45, 64'hFFFF, 0, "R10 high index write");
    cyc_op(0, 0, 0, 1, 9, "R10 CR9 read");
    wr(0, 64'h1, 16, "R3 PG off clears LMA");
    wr(16, 64'h0, 16, "R12 clear LME");
    wr(0, 64'h8000_0001, 16, "R3 no LME keeps LMA");
    sweep("R12 final read");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule